// File: doc/BRIEF.md
# Multiplexed Channel Hit Finder

This block finds pulse-shaped hits on a group of wire channels whose converter samples reach it time-interleaved on a single stream. Each accepted sample carries its channel number. One shared detector evaluates every sample against that channel's stored history. Per-channel state lives in a small register file that the channel number indexes. The state is the last few samples, an armed flag, the running peak, a width counter and a priming count.

A front edge is declared when the new sample exceeds the sample a programmable number of slots earlier by more than a rise threshold. Comparing over a lag of up to four slots lets slow-rising pulses qualify as well as sharp ones. Once armed, the channel tracks its peak. A back edge is declared when a sample falls below that peak by more than a fall threshold. The pulse counts as a hit only when its width lies inside a programmable window. The block then raises a one-cycle strobe with the channel and the current time-slot number. At the end of each time slot, marked by the sample of the highest channel, it also presents a mask of the channels that produced hits during that slot.

Top module: `mux_hit_finder`

## Requirements
- R1: During and right after reset, `hit_strobe` and `mask_valid` are 0, `hit_mask` is 0, and the time-slot counter starts from 0.
- R2: A channel cannot arm until it has accepted at least N samples since reset, where N is the effective lag. Before that, a large step against the cleared history is ignored.
- R3: An unarmed, primed channel arms when the sample minus the sample N accepted samples earlier on that channel is strictly greater than `cfg_rise_thr`. The effective lag N is `cfg_lag` clamped to 1..4: a value of 0 acts as 1 and values above 4 act as 4.
- R4: An armed channel keeps the largest sample seen since arming. It declares a back edge when the running peak minus the sample is strictly greater than `cfg_fall_thr`. The back edge always disarms the channel.
- R5: The width is the number of samples accepted after the arming sample, up to and including the back-edge sample. A hit is reported only when `cfg_min_w <= width <= cfg_max_w`. An armed channel whose width would exceed `cfg_max_w` without a back edge disarms silently. A sample that disarms a channel cannot re-arm it.
- R6: `hit_strobe` is high for one cycle, on the cycle after the qualifying sample is accepted. In that cycle `hit_chan` equals that sample's channel.
- R7: `hit_time` with a strobe equals the number of channel-15 samples accepted since reset, modulo 2^16, counted before the qualifying sample.
- R8: `mask_valid` is high for one cycle, on the cycle after each channel-15 sample. `hit_mask` bit k is then set exactly when channel k produced a hit since the previous channel-15 sample, the channel-15 sample itself included.
- R9: Channels keep fully separate state, so pulses on different channels may overlap or share a slot without interfering.
- R10: Cycles with `in_valid` low change no state and produce neither `hit_strobe` nor `mask_valid`, whatever `in_chan` and `in_sample` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_chan | input | 4 | Channel number of the sample |
| in_sample | input | 10 | Converter sample |
| cfg_lag | input | 3 | Front-edge lag in slots (clamped to 1..4) |
| cfg_rise_thr | input | 10 | Rise threshold |
| cfg_fall_thr | input | 10 | Fall-from-peak threshold |
| cfg_min_w | input | 8 | Minimum pulse width in samples |
| cfg_max_w | input | 8 | Maximum pulse width in samples |
| hit_strobe | output | 1 | One-cycle hit indication |
| hit_chan | output | 4 | Channel of the hit |
| hit_time | output | 16 | Time-slot number of the hit |
| mask_valid | output | 1 | End-of-slot mask present |
| hit_mask | output | 16 | Channels that hit during the finished slot |

## Verification
A corrupted history, peak or width entry does not show up on the cycle it goes wrong. It shows up at the next sample of the same channel, sixteen accepted samples later: a strobe appears, goes missing, or changes which slot it lands in. The reference model tracks every channel's state, and the comparison runs on each clock. Any such divergence is therefore caught on the first wrong strobe or mask. That is at most one slot after the bad state is first used. Directed pulses put slow rises, too-short and too-long widths, clamped lag values and overlapping channels in front of that comparison.

// File: rtl/mux_hit_finder.sv
module mux_hit_finder #(
  parameter int NCH    = 16,
  parameter int SW     = 10,
  parameter int MAXLAG = 4,
  parameter int WCW    = 8,
  parameter int TW     = 16,
  localparam int CW    = $clog2(NCH),
  localparam int LW    = $clog2(MAXLAG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_chan,
  input  logic [SW-1:0] in_sample,
  input  logic [LW-1:0] cfg_lag,
  input  logic [SW-1:0] cfg_rise_thr,
  input  logic [SW-1:0] cfg_fall_thr,
  input  logic [WCW-1:0] cfg_min_w,
  input  logic [WCW-1:0] cfg_max_w,
  output logic          hit_strobe,
  output logic [CW-1:0] hit_chan,
  output logic [TW-1:0] hit_time,
  output logic          mask_valid,
  output logic [NCH-1:0] hit_mask
);
  localparam int IW = (MAXLAG > 1) ? $clog2(MAXLAG) : 1;

  logic [SW-1:0]  hist_q  [NCH][MAXLAG];
  logic [LW-1:0]  seen_q  [NCH];
  logic           armed_q [NCH];
  logic [SW-1:0]  peak_q  [NCH];
  logic [WCW-1:0] width_q [NCH];
  logic [NCH-1:0] acc_q;
  logic [TW-1:0]  time_q;

  logic [LW-1:0]  lag_e;
  logic [IW-1:0]  lag_idx;
  logic [SW-1:0]  old_s, pk_s;
  logic [WCW-1:0] w_nx;
  logic           armed_c, primed, rise, fall, abort_w, qual, last_ch;
  logic [NCH-1:0] acc_nx;

  assign lag_e   = (cfg_lag == '0) ? LW'(1)
                 : (cfg_lag > LW'(MAXLAG)) ? LW'(MAXLAG) : cfg_lag;
  assign lag_idx = IW'(lag_e - LW'(1));
  assign old_s   = hist_q[in_chan][lag_idx];
  assign pk_s    = peak_q[in_chan];
  assign armed_c = armed_q[in_chan];
  assign primed  = seen_q[in_chan] >= lag_e;
  assign w_nx    = (width_q[in_chan] == '1) ? width_q[in_chan] : width_q[in_chan] + WCW'(1);

  assign rise    = !armed_c && primed && (in_sample > old_s) &&
                   ((in_sample - old_s) > cfg_rise_thr);
  assign fall    = armed_c && (pk_s > in_sample) && ((pk_s - in_sample) > cfg_fall_thr);
  assign abort_w = armed_c && !fall && (w_nx > cfg_max_w);
  assign qual    = in_valid && fall && (w_nx >= cfg_min_w) && (w_nx <= cfg_max_w);
  assign last_ch = in_chan == CW'(NCH - 1);
  assign acc_nx  = acc_q | (qual ? (NCH'(1) << in_chan) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        for (int k = 0; k < MAXLAG; k++) hist_q[c][k] <= '0;
        seen_q[c]  <= '0;
        armed_q[c] <= 1'b0;
        peak_q[c]  <= '0;
        width_q[c] <= '0;
      end
    end else if (in_valid) begin
      for (int k = MAXLAG - 1; k > 0; k--) hist_q[in_chan][k] <= hist_q[in_chan][k-1];
      hist_q[in_chan][0] <= in_sample;
      if (seen_q[in_chan] < LW'(MAXLAG)) seen_q[in_chan] <= seen_q[in_chan] + LW'(1);
      if (rise) begin
        armed_q[in_chan] <= 1'b1;
        peak_q[in_chan]  <= in_sample;
        width_q[in_chan] <= '0;
      end else if (armed_c) begin
        if (fall || abort_w) begin
          armed_q[in_chan] <= 1'b0;
        end else begin
          width_q[in_chan] <= w_nx;
          if (in_sample > pk_s) peak_q[in_chan] <= in_sample;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_strobe <= 1'b0;
      hit_chan   <= '0;
      hit_time   <= '0;
      mask_valid <= 1'b0;
      hit_mask   <= '0;
      acc_q      <= '0;
      time_q     <= '0;
    end else begin
      hit_strobe <= qual;
      mask_valid <= in_valid && last_ch;
      if (in_valid) begin
        hit_chan <= in_chan;
        hit_time <= time_q;
        if (last_ch) begin
          hit_mask <= acc_nx;
          acc_q    <= '0;
          time_q   <= time_q + TW'(1);
        end else begin
          acc_q <= acc_nx;
        end
      end
    end
  end
endmodule

module mux_hit_finder_chk #(
  parameter int NCH = 16,
  parameter int CW  = 4,
  parameter int WCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [CW-1:0]  in_chan,
  input logic [WCW-1:0] cfg_min_w,
  input logic [WCW-1:0] cfg_max_w,
  input logic           hit_strobe,
  input logic [CW-1:0]  hit_chan,
  input logic           mask_valid,
  input logic [NCH-1:0] hit_mask
);
  AST_STROBE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_strobe |-> $past(in_valid)); // R6
  AST_STROBE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_strobe |-> hit_chan == $past(in_chan)); // R6
  AST_MASK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> $past(in_valid && in_chan == CW'(NCH - 1))); // R8
  AST_LAST_HIT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_strobe && hit_chan == CW'(NCH - 1)) |-> (mask_valid && hit_mask[NCH-1])); // R8
  AST_WIDTH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_strobe |-> $past(cfg_min_w <= cfg_max_w)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!hit_strobe && !mask_valid)); // R10
endmodule

bind mux_hit_finder mux_hit_finder_chk #(.NCH(NCH), .CW(CW), .WCW(WCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .cfg_min_w(cfg_min_w), .cfg_max_w(cfg_max_w), .hit_strobe(hit_strobe),
  .hit_chan(hit_chan), .mask_valid(mask_valid), .hit_mask(hit_mask));

// File: tb/mux_hit_finder_bench.sv
module mux_hit_finder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [3:0]  in_chan = 0;
  logic [9:0]  in_sample = 0;
  logic [2:0]  cfg_lag = 1;
  logic [9:0]  cfg_rise_thr = 20;
  logic [9:0]  cfg_fall_thr = 15;
  logic [7:0]  cfg_min_w = 1;
  logic [7:0]  cfg_max_w = 5;
  logic        hit_strobe, mask_valid;
  logic [3:0]  hit_chan;
  logic [15:0] hit_time, hit_mask;

  int checks = 0, errors = 0, nhits = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mux_hit_finder u_mux_hit_finder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .cfg_lag(cfg_lag), .cfg_rise_thr(cfg_rise_thr),
    .cfg_fall_thr(cfg_fall_thr), .cfg_min_w(cfg_min_w), .cfg_max_w(cfg_max_w),
    .hit_strobe(hit_strobe), .hit_chan(hit_chan), .hit_time(hit_time),
    .mask_valid(mask_valid), .hit_mask(hit_mask));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model
  int m_hist[16][4];
  int m_seen[16], m_peak[16], m_w[16];
  bit m_arm[16];
  int m_time, m_acc;
  bit e_strobe, e_mv;
  int e_chan, e_time, e_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_hist[c, k]) m_hist[c][k] = 0;
      for (int c = 0; c < 16; c++) begin
        m_seen[c] = 0; m_peak[c] = 0; m_w[c] = 0; m_arm[c] = 0;
      end
      m_time = 0; m_acc = 0; e_strobe = 0; e_mv = 0; e_chan = 0; e_time = 0; e_mask = 0;
    end else begin
      e_strobe = 0; e_mv = 0;
      if (in_valid) begin
        int c, s, lag, old, wn;
        bit q;
        c = int'(in_chan); s = int'(in_sample);
        lag = (cfg_lag == 0) ? 1 : (cfg_lag > 4) ? 4 : int'(cfg_lag);
        old = m_hist[c][lag-1];
        q = 0;
        if (!m_arm[c]) begin
          if (m_seen[c] >= lag && s - old > int'(cfg_rise_thr)) begin
            m_arm[c] = 1; m_peak[c] = s; m_w[c] = 0;
          end
        end else begin
          wn = (m_w[c] >= 255) ? 255 : m_w[c] + 1;
          if (m_peak[c] - s > int'(cfg_fall_thr)) begin
            m_arm[c] = 0;
            q = (wn >= int'(cfg_min_w)) && (wn <= int'(cfg_max_w));
          end else if (wn > int'(cfg_max_w)) begin
            m_arm[c] = 0;
          end else begin
            m_w[c] = wn;
            if (s > m_peak[c]) m_peak[c] = s;
          end
        end
        for (int k = 3; k > 0; k--) m_hist[c][k] = m_hist[c][k-1];
        m_hist[c][0] = s;
        if (m_seen[c] < 4) m_seen[c]++;
        e_strobe = q; e_chan = c; e_time = m_time;
        if (q) m_acc = m_acc | (1 << c);
        if (c == 15) begin
          e_mv = 1; e_mask = m_acc; m_acc = 0; m_time = (m_time + 1) % 65536;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(hit_strobe == e_strobe, "R6 strobe", int'(hit_strobe), int'(e_strobe));
      if (e_strobe && hit_strobe) begin
        chk(int'(hit_chan) == e_chan, "R6 channel", int'(hit_chan), e_chan);
        chk(int'(hit_time) == e_time, "R7 time", int'(hit_time), e_time);
      end
      chk(mask_valid == e_mv, "R8 mask_valid", int'(mask_valid), int'(e_mv));
      if (e_mv && mask_valid)
        chk(int'(hit_mask) == e_mask, "R8 mask", int'(hit_mask), e_mask);
    end
  end

  always @(posedge clk) if (rst_n && hit_strobe) nhits++;

  task automatic idle();
    in_valid = 0; in_sample = 10'd999; in_chan = 4'd6;
    @(posedge clk); #1;
  endtask

  task automatic slot(int ta, int va, int tb = -1, int vb = 0);
    for (int c = 0; c < 16; c++) begin
      in_valid = 1; in_chan = 4'(c);
      in_sample = (c == ta) ? 10'(va) : (c == tb) ? 10'(vb) : 10'd100;
      @(posedge clk); #1;
      if (c == 7) idle();  // R10 gap with garbage inputs
    end
    in_valid = 0;
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) slot(-1, 0);
    idle(); idle();
  endtask

  task automatic expect_hits(int exp, string req);
    chk(nhits == exp, req, nhits, exp);
    nhits = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(hit_strobe == 0, "R1 strobe in reset", int'(hit_strobe), 0);
    chk(mask_valid == 0, "R1 mask_valid in reset", int'(mask_valid), 0);
    chk(hit_mask == 0, "R1 mask in reset", int'(hit_mask), 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(hit_strobe == 0 && mask_valid == 0, "R1 after reset", int'(hit_strobe), 0);

    // R2: lag 4, step against cleared history must not arm
    cfg_lag = 4; cfg_min_w = 1; cfg_max_w = 5;
    for (int i = 0; i < 5; i++) slot(0, 300);
    slot(0, 100);
    flush();
    expect_hits(0, "R2 priming");

    // R3 R4 R5: sharp pulse, width 2 within [2,5]
    cfg_lag = 1; cfg_min_w = 2; cfg_max_w = 5;
    slot(3, 150); slot(3, 160); slot(3, 140); slot(3, 100);
    flush();
    expect_hits(1, "R4 sharp pulse");

    // R5: width 2 below minimum 3
    cfg_min_w = 3;
    slot(5, 150); slot(5, 160); slot(5, 140); slot(5, 100);
    flush();
    expect_hits(0, "R5 too short");

    // R5: exceeds max 3 without fall
    cfg_min_w = 1; cfg_max_w = 3;
    slot(7, 150); slot(7, 160); slot(7, 170); slot(7, 180); slot(7, 190); slot(7, 100);
    flush();
    expect_hits(0, "R5 too long");

    // R5: exactly max width 3
    slot(8, 150); slot(8, 160); slot(8, 170); slot(8, 140);
    flush();
    expect_hits(1, "R5 width at max");

    // R3: slow rise seen with lag 4
    cfg_max_w = 5; cfg_lag = 4;
    slot(9, 110); slot(9, 120); slot(9, 130); slot(9, 140); slot(9, 120);
    flush();
    expect_hits(1, "R3 slow rise lag 4");

    // R3: same slow rise missed with lag 1
    cfg_lag = 1;
    slot(11, 110); slot(11, 120); slot(11, 130); slot(11, 140); slot(11, 120);
    flush();
    expect_hits(0, "R3 slow rise lag 1");

    // R3: lag 0 acts as 1
    cfg_lag = 0;
    slot(4, 130); slot(4, 100);
    flush();
    expect_hits(1, "R3 lag 0 clamp");

    // R3: lag 7 acts as 4
    cfg_lag = 7;
    slot(6, 110); slot(6, 120); slot(6, 130); slot(6, 140); slot(6, 120);
    flush();
    expect_hits(1, "R3 lag 7 clamp");

    // R9 R8: overlapping and same-slot pulses, including channel 15
    cfg_lag = 1;
    slot(1, 300, 2, 100); slot(1, 100, 2, 300); slot(2, 100);
    slot(12, 300, 13, 300); slot(12, 100, 13, 100);
    slot(15, 300); slot(15, 100);
    flush();
    expect_hits(5, "R9 interleaved channels");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule